// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block decides when one DRAM rank should be refreshed and how urgently. A free-running interval timer marks every average refresh period; each expiry adds one to a count of owed refreshes, and each refresh the memory controller grants takes one away. The count, the time the rank has spent idle and the time since the last granted refresh together set a request with one of three urgency levels. The controller's arbiter uses that level to weigh the refresh against normal traffic.

Once a refresh is granted, the block holds an activate-block output high for the programmed refresh recovery time. No new request is raised while that output is high. Every timing value is a live configuration input, and all outputs come straight from flops.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ref_req`, `ref_prio` and `act_block` are 0. Reset also clears the owed count, the idle count and all timers.
- R2: The owed count increases by one every `cfg_trefi` cycles, and it never goes above 9. The first increase happens at the end of cycle `cfg_trefi-1` after reset is released, where cycle 0 is the first cycle with `rst` low. `ref_prio` shows a change in the count one cycle after the count changes, so the first change is visible in cycle `cfg_trefi+1`.
- R3: `ref_prio` uses this encoding: 0 = none, 1 = opportunistic, 2 = high, 3 = panic. `ref_req` is 1 exactly when `ref_prio` is not 0. Only a non-zero owed count can make `ref_prio` non-zero.
- R4: The level is high (2) when the owed count is at least `cfg_hi_mark` and no higher level applies.
- R5: The level is panic (3) when the owed count is at least `cfg_panic_mark`. Panic takes precedence over every other level.
- R6: The level is opportunistic (1) when no higher level applies and `rank_idle` has been 1 for at least `cfg_idle_win` consecutive cycles. A single cycle with `rank_idle` at 0 restarts that count.
- R7: A grant is taken only when `ref_grant` is 1 in a cycle where `ref_req` is 1. A taken grant lowers the owed count by one. A `ref_grant` while `ref_req` is 0 has no effect.
- R8: After a grant is taken, `act_block` is 1 for exactly `cfg_trfc` cycles, starting in the next cycle. `ref_req` is 0 in the cycle after a taken grant and in every cycle where `act_block` is 1.
- R9: A guard timer counts elapsed units of 1024 cycles since reset or since the last taken grant. If `cfg_max_gap` is not 0, the elapsed units have reached `cfg_max_gap`, and at least one refresh is owed, the level is forced to panic. When `cfg_max_gap` is 0 the guard is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_trefi | input | 16 | Average refresh period in cycles (0 stops the timer) |
| cfg_trfc | input | 9 | Refresh recovery time in cycles |
| cfg_idle_win | input | 8 | Idle cycles needed before an early refresh |
| cfg_hi_mark | input | 4 | Owed count that raises the level to high |
| cfg_panic_mark | input | 4 | Owed count that raises the level to panic |
| cfg_max_gap | input | 8 | Longest allowed gap between refreshes, in 1024-cycle units |
| rank_idle | input | 1 | Rank has no traffic in this cycle |
| ref_grant | input | 1 | Controller takes the refresh now |
| ref_req | output | 1 | Refresh requested |
| ref_prio | output | 2 | Request urgency level |
| act_block | output | 1 | Activates and refreshes forbidden |

## Verification
The bench checks each priority transition on the exact cycle it must occur, so a design with one register too many or too few shows up as a level that is early or late. A low panic mark set one above the saturation point catches an owed counter that does not saturate: such a counter climbs to 10 and reports panic. A grant given while no request is raised catches a design that starts a blackout or loses an owed refresh. A period expiry inside a long blackout catches a design that lets the request leak through the block or that drops the increment. The guard timer is checked both before and after a grant that restarts it; a design that does not restart it would report panic about a thousand cycles too early.

// File: rtl/refsch_pkg.sv
`timescale 1ns/1ps
package refsch_pkg;
  typedef enum logic [1:0] {
    PRIO_NONE  = 2'd0,
    PRIO_OPP   = 2'd1,
    PRIO_HIGH  = 2'd2,
    PRIO_PANIC = 2'd3
  } prio_e;
endpackage

// File: rtl/refsch_interval.sv
`timescale 1ns/1ps
// Period timer and saturating owed-refresh counter.
module refsch_interval #(
  parameter int TREFI_W  = 16,
  parameter int OWED_MAX = 9,
  parameter int OWED_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TREFI_W-1:0] cfg_trefi,
  input  logic               dec,
  output logic [OWED_W-1:0]  owed
);
  localparam logic [TREFI_W-1:0] T_ONE = TREFI_W'(1);
  localparam logic [OWED_W-1:0]  O_ONE = OWED_W'(1);
  localparam logic [OWED_W-1:0]  O_MAX = OWED_W'(OWED_MAX);

  logic [TREFI_W-1:0] tcnt;
  logic               tick;

  assign tick = (cfg_trefi != '0) && (tcnt >= cfg_trefi - T_ONE);

  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else if (tick) tcnt <= '0;
    else tcnt <= tcnt + T_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      case ({tick, dec})
        2'b10: owed <= (owed == O_MAX) ? owed : owed + O_ONE;
        2'b01: owed <= (owed == '0) ? owed : owed - O_ONE;
        default: owed <= owed;
      endcase
    end
  end
endmodule

// File: rtl/refsch_idle.sv
`timescale 1ns/1ps
// Counts consecutive idle cycles, saturating.
module refsch_idle #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rank_idle,
  input  logic [IDLE_W-1:0] cfg_idle_win,
  output logic              opportunity
);
  localparam logic [IDLE_W-1:0] I_ONE = IDLE_W'(1);
  logic [IDLE_W-1:0] icnt;

  always_ff @(posedge clk) begin
    if (rst || !rank_idle) icnt <= '0;
    else if (icnt != '1) icnt <= icnt + I_ONE;
  end

  assign opportunity = (icnt >= cfg_idle_win);
endmodule

// File: rtl/refsch_gap.sv
`timescale 1ns/1ps
// Long-term guard: counts coarse units since the last taken refresh.
module refsch_gap #(
  parameter int GAP_W     = 8,
  parameter int UNIT_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [GAP_W-1:0] cfg_max_gap,
  output logic             expired
);
  localparam logic [UNIT_LOG2-1:0] P_ONE = UNIT_LOG2'(1);
  localparam logic [GAP_W-1:0]     U_ONE = GAP_W'(1);

  logic [UNIT_LOG2-1:0] pre;
  logic [GAP_W-1:0]     units;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre   <= '0;
      units <= '0;
    end else begin
      pre <= pre + P_ONE;
      if ((&pre) && (units != '1)) units <= units + U_ONE;
    end
  end

  assign expired = (cfg_max_gap != '0) && (units >= cfg_max_gap);
endmodule

// File: rtl/refsch_blackout.sv
`timescale 1ns/1ps
// Post-refresh recovery window.
module refsch_blackout #(
  parameter int TRFC_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TRFC_W-1:0] cfg_trfc,
  output logic              busy
);
  localparam logic [TRFC_W-1:0] B_ONE = TRFC_W'(1);
  logic [TRFC_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= '0;
      busy <= 1'b0;
    end else if (start) begin
      bcnt <= cfg_trfc;
      busy <= (cfg_trfc != '0);
    end else if (bcnt != '0) begin
      bcnt <= bcnt - B_ONE;
      busy <= (bcnt != B_ONE);
    end else begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
  import refsch_pkg::*;
#(
  parameter int TREFI_W   = 16,
  parameter int TRFC_W    = 9,
  parameter int IDLE_W    = 8,
  parameter int MARK_W    = 4,
  parameter int GAP_W     = 8,
  parameter int UNIT_LOG2 = 10,
  parameter int OWED_MAX  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TREFI_W-1:0] cfg_trefi,
  input  logic [TRFC_W-1:0]  cfg_trfc,
  input  logic [IDLE_W-1:0]  cfg_idle_win,
  input  logic [MARK_W-1:0]  cfg_hi_mark,
  input  logic [MARK_W-1:0]  cfg_panic_mark,
  input  logic [GAP_W-1:0]   cfg_max_gap,
  input  logic               rank_idle,
  input  logic               ref_grant,
  output logic               ref_req,
  output logic [1:0]         ref_prio,
  output logic               act_block
);
  localparam int OWED_W = $clog2(OWED_MAX + 1);

  logic [OWED_W-1:0] owed_q;
  logic              taken;
  logic              opp;
  logic              gap_hit;
  logic              blk;
  prio_e             prio_d;

  assign taken = ref_grant && ref_req;

  refsch_interval #(.TREFI_W(TREFI_W), .OWED_MAX(OWED_MAX), .OWED_W(OWED_W)) u_int (
    .clk(clk), .rst(rst), .cfg_trefi(cfg_trefi), .dec(taken), .owed(owed_q)
  );

  refsch_idle #(.IDLE_W(IDLE_W)) u_idle (
    .clk(clk), .rst(rst), .rank_idle(rank_idle),
    .cfg_idle_win(cfg_idle_win), .opportunity(opp)
  );

  refsch_gap #(.GAP_W(GAP_W), .UNIT_LOG2(UNIT_LOG2)) u_gap (
    .clk(clk), .rst(rst), .restart(taken),
    .cfg_max_gap(cfg_max_gap), .expired(gap_hit)
  );

  refsch_blackout #(.TRFC_W(TRFC_W)) u_blk (
    .clk(clk), .rst(rst), .start(taken), .cfg_trfc(cfg_trfc), .busy(blk)
  );

  // Level selection, highest urgency first.
  always_comb begin
    prio_d = PRIO_NONE;
    if (!taken && !blk && (owed_q != '0)) begin
      if ((int'(owed_q) >= int'(cfg_panic_mark)) || gap_hit) prio_d = PRIO_PANIC;
      else if (int'(owed_q) >= int'(cfg_hi_mark))            prio_d = PRIO_HIGH;
      else if (opp)                                          prio_d = PRIO_OPP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prio <= PRIO_NONE;
      ref_req  <= 1'b0;
    end else begin
      ref_prio <= prio_d;
      ref_req  <= (prio_d != PRIO_NONE);
    end
  end

  assign act_block = blk;
endmodule

// File: rtl/refsch_chk.sv
`timescale 1ns/1ps
module refsch_chk #(
  parameter int OWED_W   = 4,
  parameter int OWED_MAX = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_grant,
  input logic              ref_req,
  input logic [1:0]        ref_prio,
  input logic              act_block,
  input logic [OWED_W-1:0] owed
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (ref_prio == 2'd0 && !ref_req && !act_block));
  // R2
  owed_sat_chk: assert property (@(posedge clk) disable iff (rst) int'(owed) <= OWED_MAX);
  // R3
  req_level_chk: assert property (@(posedge clk) disable iff (rst) ref_req == (ref_prio != 2'd0));
  // R8
  block_quiet_chk: assert property (@(posedge clk) disable iff (rst) act_block |-> !ref_req);
  // R8
  block_cause_chk: assert property (@(posedge clk) disable iff (rst) $rose(act_block) |-> $past(ref_grant && ref_req));
  // R7
  grant_drop_chk: assert property (@(posedge clk) disable iff (rst) (ref_grant && ref_req) |=> !ref_req);
endmodule

bind refresh_sched refsch_chk #(.OWED_W(OWED_W), .OWED_MAX(OWED_MAX)) u_chk (
  .clk(clk), .rst(rst), .ref_grant(ref_grant), .ref_req(ref_req),
  .ref_prio(ref_prio), .act_block(act_block), .owed(owed_q)
);

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_trefi = '0;
  logic [8:0]  cfg_trfc = '0;
  logic [7:0]  cfg_idle_win = '0;
  logic [3:0]  cfg_hi_mark = '0;
  logic [3:0]  cfg_panic_mark = '0;
  logic [7:0]  cfg_max_gap = '0;
  logic        rank_idle = 1'b0;
  logic        ref_grant = 1'b0;
  logic        ref_req;
  logic [1:0]  ref_prio;
  logic        act_block;

  refresh_sched u0 (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  int base = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int rel; logic [1:0] prio; logic blk; string tag; } exp_t;
  exp_t q[$];

  task automatic check(input logic [1:0] p, input logic b, input string tag);
    nchk++;
    if (ref_prio !== p || act_block !== b || ref_req !== (p != 2'd0)) begin
      nfail++;
      $display("FAIL %s: prio=%0d blk=%0d req=%0d expected prio=%0d blk=%0d req=%0d",
               tag, ref_prio, act_block, ref_req, p, b, (p != 2'd0));
    end
  endtask

  task automatic push(input int rel, input logic [1:0] p, input logic b, input string tag);
    exp_t e;
    e.rel = rel; e.prio = p; e.blk = b; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares the head of the scoreboard on its cycle.
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      while (q.size() > 0 && q[0].rel <= cyc - base) begin
        e = q.pop_front();
        if (e.rel < cyc - base) begin
          nchk++; nfail++;
          $display("FAIL %s: missed cycle %0d, expected prio=%0d", e.tag, e.rel, e.prio);
        end else begin
          check(e.prio, e.blk, e.tag);
        end
      end
    end
  end

  task automatic restart(input int trefi, input int trfc, input int iwin,
                         input int hi, input int pan, input int gap, input logic idle);
    @(negedge clk);
    rst = 1'b1; ref_grant = 1'b0;
    cfg_trefi = 16'(trefi); cfg_trfc = 9'(trfc); cfg_idle_win = 8'(iwin);
    cfg_hi_mark = 4'(hi); cfg_panic_mark = 4'(pan); cfg_max_gap = 8'(gap);
    rank_idle = idle;
    repeat (3) @(negedge clk);
    check(2'd0, 1'b0, "R1 in reset");
    rst = 1'b0;
    base = cyc;
  endtask

  task automatic wait_rel(input int n);
    while (cyc - base < n) @(negedge clk);
  endtask

  task automatic grant_at(input int n);
    wait_rel(n);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    // Escalation by marks, ignored grant, decrement by one
    restart(20, 1, 255, 2, 4, 0, 1'b0);
    push(1, 2'd0, 1'b0, "R1 after release");
    push(6, 2'd0, 1'b0, "R7 stray grant no block");
    push(21, 2'd0, 1'b0, "R4 below high mark");
    push(40, 2'd0, 1'b0, "R2 latency before high");
    push(41, 2'd2, 1'b0, "R4 high at mark");
    push(80, 2'd2, 1'b0, "R5 before panic");
    push(81, 2'd3, 1'b0, "R5 panic at mark");
    push(82, 2'd0, 1'b1, "R8 blocked after grant");
    push(83, 2'd0, 1'b0, "R8 block length 1");
    push(84, 2'd2, 1'b0, "R7 owed decremented by one");
    push(100, 2'd2, 1'b0, "R2 before refill");
    push(101, 2'd3, 1'b0, "R7 refill to panic");
    grant_at(5);
    grant_at(81);
    drain();

    // Saturation at 9
    restart(4, 1, 255, 9, 10, 0, 1'b0);
    push(36, 2'd0, 1'b0, "R2 eight owed");
    push(37, 2'd2, 1'b0, "R2 nine owed");
    push(60, 2'd2, 1'b0, "R2 saturates at 9");
    drain();

    // Long blackout hides a period expiry
    restart(20, 30, 255, 1, 15, 0, 1'b0);
    push(21, 2'd2, 1'b0, "R4 high with mark 1");
    push(22, 2'd0, 1'b1, "R8 block start");
    push(51, 2'd0, 1'b1, "R8 block end");
    push(52, 2'd0, 1'b0, "R8 block released");
    push(53, 2'd2, 1'b0, "R8 request after block");
    grant_at(21);
    drain();

    // Opportunistic window
    restart(20, 1, 10, 3, 15, 0, 1'b1);
    push(20, 2'd0, 1'b0, "R6 none before owed");
    push(21, 2'd1, 1'b0, "R6 opportunistic");
    push(26, 2'd1, 1'b0, "R6 idle drop latency");
    push(27, 2'd0, 1'b0, "R6 idle broken");
    push(40, 2'd0, 1'b0, "R6 window restarting");
    push(41, 2'd1, 1'b0, "R6 window refilled");
    wait_rel(25); rank_idle = 1'b0;
    wait_rel(30); rank_idle = 1'b1;
    drain();

    // Maximum-gap guard
    restart(1500, 2, 255, 15, 15, 2, 1'b0);
    push(1501, 2'd0, 1'b0, "R9 owed but gap open");
    push(2048, 2'd0, 1'b0, "R9 before gap");
    push(2049, 2'd3, 1'b0, "R9 forced panic");
    push(2051, 2'd0, 1'b1, "R8 two-cycle block");
    push(3001, 2'd0, 1'b0, "R9 gap restarted");
    push(4098, 2'd0, 1'b0, "R9 before second gap");
    push(4099, 2'd3, 1'b0, "R9 second forced panic");
    grant_at(2049);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule